// File: doc/BRIEF.md
# Page-Splitting DMA Descriptor Generator

This block takes one transfer request and turns it into an ordered stream of DMA descriptors. A request has a start address, a byte length and a direction. No descriptor's byte range crosses a memory page boundary. Physical addresses equal virtual addresses. The descriptors leave one per cycle on a valid/ready port. Each descriptor carries a 3-bit command, a byte count and an address. A STOP descriptor always closes the stream.

The block also derives the value a 16-bit transfer-count register should receive for the same request. It rejects requests that are too large with a one-cycle error pulse and emits nothing for them. A one-cycle done pulse follows the handshake of the STOP descriptor.

The block has no descriptor memory and does not execute the descriptors it produces. Downstream logic stores and executes them.

Top module: `page_desc_gen`

## Requirements
- R1: After reset, desc_valid, busy, err and done are 0 and tc_value is 0.
- R2: start is accepted only while busy is 0. A start pulse while busy is 1 does not change the descriptor stream or tc_value.
- R3: No data descriptor spans a page boundary: the address offset within its page plus its count is at most the page size (4096 bytes by default). If the start address is unaligned and the length goes past the end of that page, the first descriptor covers exactly the bytes up to the page end.
- R4: Every data descriptor except the final one has a MORE command, and it ends exactly on a page boundary. Once the address is page-aligned, each such descriptor has a count of one full page.
- R5: The final data descriptor carries the remaining count, which is at most one page, with a LAST command.
- R6: The command code is 3 bits. A write (dir_in=0) uses OUT_MORE=0 and OUT_LAST=1. A read into memory (dir_in=1) uses IN_MORE=2 and IN_LAST=3.
- R7: Right after the final data descriptor comes a STOP descriptor: command 7, count 0, address 0.
- R8: A request is rejected when floor(length / page size) exceeds 32. On rejection, err is 1 for exactly the cycle after start, and no descriptor is produced. The block stays idle and tc_value keeps its previous value.
- R9: In the cycle after a start is accepted, tc_value holds the low 16 bits of the length, so a length of 65536 gives 0. tc_value holds that value until the next accepted start.
- R10: A zero-length request produces one LAST descriptor with count 0 at the start address, followed by STOP.
- R11: While desc_valid is 1 and desc_ready is 0, the descriptor on the port holds unchanged.
- R12: done is 1 for exactly the one cycle after the STOP descriptor's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| start_addr | input | 32 | First byte address |
| xfer_len | input | 18 | Byte length of the request |
| dir_in | input | 1 | 1 = device to memory, 0 = memory to device |
| busy | output | 1 | Stream in progress |
| err | output | 1 | Request rejected as too large |
| done | output | 1 | Pulse after the STOP handshake |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_cmd | output | 3 | Command code |
| desc_count | output | 13 | Byte count |
| desc_addr | output | 32 | Byte address |
| tc_value | output | 16 | Transfer-count register value |

## Verification
The bound checker checks the following on every cycle:
- the page-boundary limit on data descriptors, and that every MORE descriptor ends exactly on a boundary;
- the zero fields of STOP and its position right after LAST;
- stability of the descriptor under back-pressure;
- that err never coincides with activity, and that done has a matching STOP handshake one cycle earlier.

Only the bench scenarios can show that the whole stream is correct, because the exact counts and addresses depend on the request. This covers the unaligned first fragment, the full-page middle, the zero-length and 65536-byte cases, and the 32-page rejection limit. The bench scenarios also cover the tc_value encoding and the fact that a start while busy is ignored.

// File: rtl/page_desc_gen.sv
module page_desc_gen #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 18,
  parameter int PAGE_BITS = 12,
  parameter int MAX_PAGES = 32,
  parameter int TC_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [LEN_W-1:0]     xfer_len,
  input  logic                 dir_in,
  output logic                 busy,
  output logic                 err,
  output logic                 done,
  output logic                 desc_valid,
  input  logic                 desc_ready,
  output logic [2:0]           desc_cmd,
  output logic [PAGE_BITS:0]   desc_count,
  output logic [ADDR_W-1:0]    desc_addr,
  output logic [TC_W-1:0]      tc_value
);
  localparam int CNT_W = PAGE_BITS + 1;
  localparam int PAGE  = 1 << PAGE_BITS;
  localparam logic [2:0] CMD_STOP = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_STOP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic              dir_q;

  logic [CNT_W-1:0]  room;
  logic              fits;
  logic [CNT_W-1:0]  data_cnt;
  logic              accept;
  logic              too_big;
  logic              take;

  assign room     = CNT_W'(PAGE) - {1'b0, cur_addr[PAGE_BITS-1:0]};
  assign fits     = remain <= LEN_W'(room);
  assign data_cnt = fits ? remain[CNT_W-1:0] : room;
  assign too_big  = (xfer_len >> PAGE_BITS) > LEN_W'(MAX_PAGES);
  assign accept   = start && (st == S_IDLE);
  assign take     = desc_valid && desc_ready;

  assign busy       = (st != S_IDLE);
  assign desc_valid = (st != S_IDLE);
  assign desc_cmd   = (st == S_STOP) ? CMD_STOP : {1'b0, dir_q, fits};
  assign desc_count = (st == S_DATA) ? data_cnt : '0;
  assign desc_addr  = (st == S_DATA) ? cur_addr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      dir_q    <= 1'b0;
      err      <= 1'b0;
      done     <= 1'b0;
      tc_value <= '0;
    end else begin
      err  <= accept && too_big;
      done <= (st == S_STOP) && desc_ready;
      case (st)
        S_IDLE: if (accept && !too_big) begin
          st       <= S_DATA;
          cur_addr <= start_addr;
          remain   <= xfer_len;
          dir_q    <= dir_in;
          tc_value <= TC_W'(xfer_len);
        end
        S_DATA: if (take) begin
          if (fits) st <= S_STOP;
          else begin
            cur_addr <= cur_addr + ADDR_W'(room);
            remain   <= remain - LEN_W'(room);
          end
        end
        S_STOP: if (take) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_desc_gen_chk.sv
module page_desc_gen_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               err,
  input logic               done,
  input logic               desc_valid,
  input logic               desc_ready,
  input logic [2:0]         desc_cmd,
  input logic [PAGE_BITS:0] desc_count,
  input logic [ADDR_W-1:0]  desc_addr
);
  localparam int PAGE = 1 << PAGE_BITS;

  logic [PAGE_BITS+1:0] end_off;
  logic is_data, is_more, is_last, is_stop;
  assign end_off = {2'b00, desc_addr[PAGE_BITS-1:0]} + {1'b0, desc_count};
  assign is_stop = desc_cmd == 3'd7;
  assign is_data = desc_cmd <= 3'd3;
  assign is_more = desc_cmd == 3'd0 || desc_cmd == 3'd2;
  assign is_last = desc_cmd == 3'd1 || desc_cmd == 3'd3;

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_cmd) &&
      $stable(desc_count) && $stable(desc_addr));

  a_r3_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && is_data |-> end_off <= (PAGE_BITS+2)'(PAGE));

  a_r4_more_ends_page: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && is_more |-> end_off == (PAGE_BITS+2)'(PAGE));

  a_r7_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && is_stop |-> desc_count == '0 && desc_addr == '0);

  a_r7_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready && is_last |=> desc_valid && is_stop);

  a_r6_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> is_data || is_stop);

  a_r12_done_src: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(desc_valid && desc_ready && is_stop));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !desc_valid && !busy && !done);
endmodule

bind page_desc_gen page_desc_gen_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .done(done),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_cmd(desc_cmd),
  .desc_count(desc_count), .desc_addr(desc_addr)
);

// File: tb/sim_page_desc_gen.sv
module sim_page_desc_gen;
  localparam int PAGE = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [17:0] xfer_len = '0;
  logic        dir_in = 1'b0;
  logic        desc_ready = 1'b1;
  logic        busy, err, done, desc_valid;
  logic [2:0]  desc_cmd;
  logic [12:0] desc_count;
  logic [31:0] desc_addr;
  logic [15:0] tc_value;

  int  tests = 0;
  int  fails = 0;
  int  done_seen = 0;
  bit  stall_en = 1'b0;
  bit  exp_done = 1'b0;
  bit  finished = 1'b0;
  logic [47:0] exp_q[$];

  always #2.5 clk = ~clk;

  page_desc_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .xfer_len(xfer_len), .dir_in(dir_in), .busy(busy), .err(err), .done(done),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_cmd(desc_cmd),
    .desc_count(desc_count), .desc_addr(desc_addr), .tc_value(tc_value)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    desc_ready = stall_en ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  // monitor: compares each handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done || exp_done) check(done == exp_done, "R12", "done pulse", done, exp_done);
      if (done) done_seen++;
      exp_done = desc_valid && desc_ready && desc_cmd == 3'd7;
      if (desc_valid && desc_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R2", "unexpected descriptor", {desc_cmd, desc_count, desc_addr}, 0);
        else begin
          logic [47:0] e;
          e = exp_q.pop_front();
          check({desc_cmd, desc_count, desc_addr} == e, "R3 R4 R5 R6 R7 R10",
                "descriptor {cmd,count,addr}", {desc_cmd, desc_count, desc_addr}, e);
        end
      end
    end
  end

  task automatic push_expected(input logic [31:0] a, input int len, input bit din);
    int rem = len;
    logic [31:0] ad = a;
    int off = a % PAGE;
    logic [2:0] more = din ? 3'd2 : 3'd0;
    logic [2:0] last = din ? 3'd3 : 3'd1;
    if (off != 0 && rem > PAGE - off) begin
      exp_q.push_back({more, 13'(PAGE - off), ad});
      rem -= PAGE - off;
      ad  += 32'(PAGE - off);
    end
    while (rem > PAGE) begin
      exp_q.push_back({more, 13'(PAGE), ad});
      rem -= PAGE;
      ad  += 32'(PAGE);
    end
    exp_q.push_back({last, 13'(rem), ad});
    exp_q.push_back({3'd7, 13'd0, 32'd0});
  endtask

  task automatic pulse_start(input logic [31:0] a, input int len, input bit din);
    start_addr = a;
    xfer_len   = 18'(len);
    dir_in     = din;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_req(input logic [31:0] a, input int len, input bit din,
                         input bit poke_busy);
    int d0 = done_seen;
    while (busy) @(negedge clk);
    push_expected(a, len, din);
    pulse_start(a, len, din);
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    check(tc_value == 16'(len), "R9", "tc_value", tc_value, 16'(len));
    if (poke_busy) begin
      pulse_start(32'h0000_0ABC, 7, ~din);
      check(tc_value == 16'(len), "R2", "tc_value after ignored start", tc_value, 16'(len));
    end
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(done_seen == d0 + 1, "R12", "done pulses per request", done_seen - d0, 1);
  endtask

  task automatic run_err(input logic [31:0] a, input int len);
    logic [15:0] tc0;
    while (busy) @(negedge clk);
    tc0 = tc_value;
    pulse_start(a, len, 1'b0);
    check(err == 1'b1, "R8", "err pulse", err, 1);
    check(desc_valid == 1'b0 && busy == 1'b0, "R8", "no stream on reject", desc_valid, 0);
    @(negedge clk);
    check(err == 1'b0, "R8", "err one cycle only", err, 0);
    check(desc_valid == 1'b0, "R8", "still no descriptor", desc_valid, 0);
    check(tc_value == tc0, "R8", "tc_value kept", tc_value, tc0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(desc_valid == 0 && busy == 0 && err == 0 && done == 0, "R1", "outputs in reset",
          {desc_valid, busy, err, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(desc_valid == 0 && busy == 0 && err == 0 && done == 0, "R1", "idle after reset",
          {desc_valid, busy, err, done}, 0);
    check(tc_value == 0, "R1", "tc_value after reset", tc_value, 0);

    run_req(32'h0000_1000, 3 * PAGE, 1'b0, 1'b0);    // R4 aligned full pages
    run_req(32'h0000_2F00, 5000, 1'b1, 1'b0);        // R3 unaligned first fragment
    run_req(32'h0000_0010, 100, 1'b0, 1'b0);         // R5 fits in one page
    run_req(32'h0000_5123, 0, 1'b1, 1'b0);           // R10 zero length
    stall_en = 1'b1;
    run_req(32'h0010_0000, 65536, 1'b1, 1'b0);       // R9 64 KiB -> 0, R11 stalls
    run_req(32'h0020_0800, 70000, 1'b0, 1'b0);       // R9 low bits
    run_req(32'h0030_0123, 33 * PAGE - 1, 1'b1, 1'b0); // R8 largest accepted
    run_req(32'h0000_0FFF, 2, 1'b0, 1'b1);           // R2 start while busy
    stall_en = 1'b0;
    run_req(32'h0040_0FFF, 1, 1'b1, 1'b1);           // R2 R6 one byte
    run_err(32'h0000_0000, 33 * PAGE);               // R8 rejected
    run_err(32'h0000_0040, 200000);                  // R8 rejected
    run_req(32'h0050_0000, PAGE, 1'b0, 1'b0);        // R5 exactly one page

    check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule